// File: doc/BRIEF.md
# Grouped Prioritized Interrupt Controller

This block collects interrupt lines organised into 25 groups of four lines each and turns them into two requests for a processor: a non-maskable line fed by the first two groups, and a maskable request with a priority level fed by the remaining 23 groups. Each group detects events on its four lines according to a per-group trigger mode. It latches them as request bits, gates them with a four-bit enable mask and, for maskable groups, carries a priority level.

Software reaches the block over a byte-wide register bus. A two-bit block select picks one of three spaces: the per-group control registers, a read-only acknowledge register that names the winning maskable group, and a packed trigger-mode register. Reads are combinational and have no side effects. Writes take effect at the clock edge on which the write enable is high.

Top module: `gpic_top`

## Requirements
- R1: After reset every group has enable mask 0xF, priority level 0 and trigger mode 0 (falling edge), with no request. Every trigger-mode byte reads 0, and `nmi_o`, `irq_o` and `irq_level_o` are 0.
- R2: In the control block (`bus_blk_i` = 0), the group is (`bus_off_i` / 8) modulo 25 and the register is `bus_off_i` modulo 8, so offsets 200 to 255 alias groups 0 to 6.
- R3: Trigger mode per group: 0 sets a request bit on a falling edge of its line, 1 on a rising edge, 2 on either edge, and 3 on every cycle the line is high. A line is compared with its value at the previous clock edge, which is 0 after reset. Detection sets bits on the same edge as any software write, after the write has been applied.
- R4: Reading register 0 of a maskable group (groups 2 to 24) returns the raw request bits in bits 7:4 and the request bits ANDed with the enables in bits 3:0.
- R5: Writing register 0 of a maskable group first keeps only the request bits whose bit in wdata[3:0] is 1. It then sets each request bit whose bits in both wdata[7:4] and wdata[3:0] are 1.
- R6: Writing register 1 of a maskable group loads the enable mask from wdata[3:0] and the level from wdata[6:4]. Reading it returns {0, level, enable} in the same positions.
- R7: For groups 0 and 1, register 0 reads the request bits in bits 3:0 with bits 7:4 at 0, and a write clears each request bit whose wdata[3:0] bit is 1. Register 1 reads 0, and writes to it are ignored.
- R8: `nmi_o` is 1 in the cycle after a clock edge at which group 0 or group 1 holds an enabled request, and 0 otherwise.
- R9: Among maskable groups with an enabled request, the lowest level wins, and on equal levels the lowest group index wins. One cycle after the state, `irq_o` is 1 and `irq_level_o` carries the winner's level; with no winner both are 0.
- R10: Reading acknowledge offset 0 (`bus_blk_i` = 1) returns the current winner's group index, or 0 when no maskable group has an enabled request.
- R11: Writes to the acknowledge block are ignored. Undefined control registers (2 to 7), acknowledge offsets other than 0, trigger offsets 7 and above, and block 3 all read 0.
- R12: The trigger-mode register (`bus_blk_i` = 2) holds the mode of group g at bit 2g of a 50-bit field, exposed as bytes at offsets 0 to 6. Writes load the addressed byte, and bits beyond bit 49 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 100 | Interrupt lines, group g line j at bit 4g+j |
| bus_blk_i | input | 2 | Block select: 0 control, 1 acknowledge, 2 trigger mode |
| bus_off_i | input | 8 | Byte offset within the selected block |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data |
| nmi_o | output | 1 | Non-maskable interrupt request |
| irq_o | output | 1 | Maskable interrupt request |
| irq_level_o | output | 3 | Level of the winning maskable group |

## Verification
Request bits, register reads and the acknowledge value reflect a line event or a bus write as soon as the clock edge that captures it has passed. `nmi_o`, `irq_o` and `irq_level_o` follow one edge later, because they are registered from that state. The bench drives every stimulus at a falling clock edge and lets one rising edge pass. Before that edge it computes the expected output values from its model. It compares them with the registered outputs at the next falling edge and then compares reads against the updated model, so each result is checked in the cycle it is due.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    typedef enum logic [1:0] {
        TRIG_FALL = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_HIGH = 2'd3
    } trig_e;

    localparam logic [1:0] BLK_CTL  = 2'd0;
    localparam logic [1:0] BLK_ACK  = 2'd1;
    localparam logic [1:0] BLK_TRIG = 2'd2;

    localparam int GRP_STRIDE_LOG2 = 3;

endpackage

// File: rtl/gpic_group.sv
module gpic_group
    import gpic_pkg::*;
#(
    parameter int LINES   = 4,
    parameter int LEVEL_W = 3,
    parameter bit IS_NMI  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   lines_i,
    input  trig_e              trig_i,
    input  logic               wr_ctl0_i,
    input  logic               wr_ctl1_i,
    input  logic [7:0]         wdata_i,
    output logic [LINES-1:0]   req_o,
    output logic [LINES-1:0]   en_o,
    output logic [LEVEL_W-1:0] lvl_o
);

    logic [LINES-1:0] prev_q, req_q, req_n, det;
    logic [LINES-1:0] wr_id, wr_ir;

    assign wr_id = wdata_i[LINES-1:0];
    assign wr_ir = wdata_i[2*LINES-1:LINES];

    always_comb begin
        unique case (trig_i)
            TRIG_FALL: det = prev_q & ~lines_i;
            TRIG_RISE: det = ~prev_q & lines_i;
            TRIG_BOTH: det = prev_q ^ lines_i;
            TRIG_HIGH: det = lines_i;
            default:   det = '0;
        endcase
    end

    always_comb begin
        req_n = req_q;
        if (wr_ctl0_i) begin
            if (IS_NMI) req_n = req_q & ~wr_id;
            else        req_n = (req_q & wr_id) | (wr_ir & wr_id);
        end
        req_n = req_n | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= lines_i;
            req_q  <= req_n;
        end
    end

    assign req_o = req_q;

    generate
        if (IS_NMI) begin : g_nmi
            assign en_o  = '1;
            assign lvl_o = '0;

            p_nmi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ctl0_i && det == '0) |=> ((req_q & $past(wr_id)) == '0));
        end else begin : g_lvl
            logic [LINES-1:0]   en_q;
            logic [LEVEL_W-1:0] lvl_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q  <= '1;
                    lvl_q <= '0;
                end else if (wr_ctl1_i) begin
                    en_q  <= wdata_i[LINES-1:0];
                    lvl_q <= wdata_i[LINES +: LEVEL_W];
                end
            end

            assign en_o  = en_q;
            assign lvl_o = lvl_q;

            p_ctl1_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ctl1_i |=> (en_q == $past(wdata_i[LINES-1:0])
                               && lvl_q == $past(wdata_i[LINES +: LEVEL_W])));

            p_ctl0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ctl0_i && det == '0) |=> ((req_q & ~$past(wr_id)) == '0));
        end
    endgenerate

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter #(
    parameter int NUM_GROUPS = 25,
    parameter int FIRST_LVL  = 2,
    parameter int LEVEL_W    = 3,
    localparam int IDX_W     = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0]              pend_i,
    input  logic [NUM_GROUPS-1:0][LEVEL_W-1:0] lvl_i,
    output logic                               win_valid_o,
    output logic [IDX_W-1:0]                   win_idx_o,
    output logic [LEVEL_W-1:0]                 win_lvl_o
);

    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_lvl_o   = '0;
        for (int g = FIRST_LVL; g < NUM_GROUPS; g++) begin
            if (pend_i[g] && (!win_valid_o || lvl_i[g] < win_lvl_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(g);
                win_lvl_o   = lvl_i[g];
            end
        end
    end

endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int NUM_GROUPS = 25,
    parameter int NUM_NMI    = 2,
    parameter int LINES      = 4,
    parameter int LEVEL_W    = 3,
    localparam int N_LINES   = NUM_GROUPS * LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines_i,
    input  logic [1:0]         bus_blk_i,
    input  logic [7:0]         bus_off_i,
    input  logic               bus_we_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    output logic               nmi_o,
    output logic               irq_o,
    output logic [LEVEL_W-1:0] irq_level_o
);

    localparam int IDX_W      = $clog2(NUM_GROUPS);
    localparam int TRIG_BITS  = 2 * NUM_GROUPS;
    localparam int TRIG_BYTES = (TRIG_BITS + 7) / 8;

    logic [NUM_GROUPS-1:0][LINES-1:0]   req, en;
    logic [NUM_GROUPS-1:0][LEVEL_W-1:0] lvl;
    logic [NUM_GROUPS-1:0]              pend;
    logic [TRIG_BITS-1:0]               trig_q;
    logic [TRIG_BYTES*8-1:0]            trig_pad;
    logic [IDX_W-1:0]                   ctl_grp;
    logic [2:0]                         ctl_reg;
    logic                               ctl_wr;
    logic                               win_valid;
    logic [IDX_W-1:0]                   win_idx;
    logic [LEVEL_W-1:0]                 win_lvl;
    logic                               nmi_pend;

    assign ctl_grp = IDX_W'((bus_off_i >> GRP_STRIDE_LOG2) % NUM_GROUPS);
    assign ctl_reg = bus_off_i[2:0];
    assign ctl_wr  = bus_we_i && (bus_blk_i == BLK_CTL);

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            gpic_group #(
                .LINES  (LINES),
                .LEVEL_W(LEVEL_W),
                .IS_NMI (g < NUM_NMI)
            ) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .lines_i  (irq_lines_i[g*LINES +: LINES]),
                .trig_i   (trig_e'(trig_q[2*g +: 2])),
                .wr_ctl0_i(ctl_wr && ctl_grp == IDX_W'(g) && ctl_reg == 3'd0),
                .wr_ctl1_i(ctl_wr && ctl_grp == IDX_W'(g) && ctl_reg == 3'd1),
                .wdata_i  (bus_wdata_i),
                .req_o    (req[g]),
                .en_o     (en[g]),
                .lvl_o    (lvl[g])
            );
            assign pend[g] = |(req[g] & en[g]);
        end
    endgenerate

    assign nmi_pend = |pend[NUM_NMI-1:0];

    gpic_arbiter #(
        .NUM_GROUPS(NUM_GROUPS),
        .FIRST_LVL (NUM_NMI),
        .LEVEL_W   (LEVEL_W)
    ) u_arb (
        .pend_i     (pend),
        .lvl_i      (lvl),
        .win_valid_o(win_valid),
        .win_idx_o  (win_idx),
        .win_lvl_o  (win_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (bus_we_i && bus_blk_i == BLK_TRIG) begin
            for (int i = 0; i < TRIG_BITS; i++) begin
                if (bus_off_i == 8'(i / 8)) trig_q[i] <= bus_wdata_i[i % 8];
            end
        end
    end

    assign trig_pad = (TRIG_BYTES*8)'(trig_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_o       <= 1'b0;
            irq_o       <= 1'b0;
            irq_level_o <= '0;
        end else begin
            nmi_o       <= nmi_pend;
            irq_o       <= win_valid;
            irq_level_o <= win_valid ? win_lvl : '0;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_blk_i)
            BLK_CTL: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (ctl_grp == IDX_W'(g)) begin
                        if (g < NUM_NMI) begin
                            if (ctl_reg == 3'd0) bus_rdata_o = 8'(req[g]);
                        end else if (ctl_reg == 3'd0) begin
                            bus_rdata_o = 8'({req[g], req[g] & en[g]});
                        end else if (ctl_reg == 3'd1) begin
                            bus_rdata_o = 8'({lvl[g], en[g]});
                        end
                    end
                end
            end
            BLK_ACK: begin
                if (bus_off_i == 8'd0 && win_valid) bus_rdata_o = 8'(win_idx);
            end
            BLK_TRIG: begin
                for (int b = 0; b < TRIG_BYTES; b++) begin
                    if (bus_off_i == 8'(b)) bus_rdata_o = trig_pad[b*8 +: 8];
                end
            end
            default: bus_rdata_o = '0;
        endcase
    end

    p_nmi_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |=> nmi_o);

    p_nmi_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(nmi_pend));

    p_win_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_idx] && win_idx >= IDX_W'(NUM_NMI)));

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (!irq_o && irq_level_o == '0));

    p_ack_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_blk_i == BLK_ACK && bus_rdata_o != 8'd0)
            |-> (bus_rdata_o >= 8'(NUM_NMI) && bus_rdata_o < 8'(NUM_GROUPS)));

endmodule

// File: tb/gpic_top_tb.sv
module gpic_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 25;
    localparam int NL = NG * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_lines = '0;
    logic [1:0]    bus_blk = '0;
    logic [7:0]    bus_off = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          nmi_o, irq_o;
    logic [2:0]    irq_level_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0]  m_req [NG];
    logic [3:0]  m_en  [NG];
    logic [2:0]  m_lvl [NG];
    logic [49:0] m_trig;
    logic [NL-1:0] m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines),
        .bus_blk_i(bus_blk), .bus_off_i(bus_off), .bus_we_i(bus_we),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .nmi_o(nmi_o), .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic mwin(output bit v, output int idx, output logic [2:0] lv);
        v = 0; idx = 0; lv = 0;
        for (int g = 2; g < NG; g++) begin
            if ((m_req[g] & m_en[g]) != 0 && (!v || m_lvl[g] < lv)) begin
                v = 1; idx = g; lv = m_lvl[g];
            end
        end
    endtask

    function automatic logic [7:0] mrd(input logic [1:0] blk, input logic [7:0] off);
        int g, r, idx;
        bit v;
        logic [2:0] lv;
        logic [55:0] tp;
        g = (int'(off) / 8) % NG;
        r = int'(off) % 8;
        mrd = 8'h00;
        case (blk)
            2'd0: begin
                if (g < 2) begin
                    if (r == 0) mrd = {4'h0, m_req[g]};
                end else if (r == 0) mrd = {m_req[g], m_req[g] & m_en[g]};
                else if (r == 1) mrd = {1'b0, m_lvl[g], m_en[g]};
            end
            2'd1: begin
                v = 0; idx = 0; lv = 0;
                for (int k = 2; k < NG; k++)
                    if ((m_req[k] & m_en[k]) != 0 && (!v || m_lvl[k] < lv)) begin
                        v = 1; idx = k; lv = m_lvl[k];
                    end
                if (off == 0 && v) mrd = 8'(idx);
            end
            2'd2: begin
                tp = {6'b0, m_trig};
                if (off < 7) mrd = tp[int'(off)*8 +: 8];
            end
            default: mrd = 8'h00;
        endcase
    endfunction

    task automatic mupdate(input logic [NL-1:0] ln, input logic we, input logic [1:0] blk,
                           input logic [7:0] off, input logic [7:0] wd);
        int g, r;
        logic [3:0] det;
        g = (int'(off) / 8) % NG;
        r = int'(off) % 8;
        for (int k = 0; k < NG; k++) begin
            logic [3:0] p, c;
            p = m_prev[k*4 +: 4];
            c = ln[k*4 +: 4];
            case (m_trig[2*k +: 2])
                2'd0: det = p & ~c;
                2'd1: det = ~p & c;
                2'd2: det = p ^ c;
                default: det = c;
            endcase
            if (we && blk == 2'd0 && g == k) begin
                if (k < 2) begin
                    if (r == 0) m_req[k] = m_req[k] & ~wd[3:0];
                end else if (r == 0) begin
                    m_req[k] = (m_req[k] & wd[3:0]) | (wd[7:4] & wd[3:0]);
                end else if (r == 1) begin
                    m_en[k] = wd[3:0];
                    m_lvl[k] = wd[6:4];
                end
            end
            m_req[k] = m_req[k] | det;
        end
        if (we && blk == 2'd2)
            for (int i = 0; i < 50; i++)
                if (int'(off) == i / 8) m_trig[i] = wd[i % 8];
        m_prev = ln;
    endtask

    // One clock step; registered outputs are checked against the model state before the edge.
    task automatic step(input logic [NL-1:0] ln, input logic we, input logic [1:0] blk,
                        input logic [7:0] off, input logic [7:0] wd);
        bit e_nmi, e_irq;
        int e_idx;
        logic [2:0] e_lvl;
        e_nmi = ((m_req[0] & m_en[0]) != 0) || ((m_req[1] & m_en[1]) != 0);
        mwin(e_irq, e_idx, e_lvl);
        irq_lines = ln; bus_we = we; bus_blk = blk; bus_off = off; bus_wdata = wd;
        @(posedge clk);
        mupdate(ln, we, blk, off, wd);
        @(negedge clk);
        bus_we = 1'b0;
        chk(nmi_o === e_nmi, "R8 nmi_o", nmi_o, e_nmi);
        chk(irq_o === e_irq && irq_level_o === (e_irq ? e_lvl : 3'd0), "R9 irq/level",
            {irq_o, irq_level_o}, {e_irq, e_irq ? e_lvl : 3'd0});
    endtask

    task automatic idle();
        step(m_prev, 1'b0, 2'd0, 8'd0, 8'd0);
    endtask

    task automatic wr(input logic [1:0] blk, input logic [7:0] off, input logic [7:0] wd);
        step(m_prev, 1'b1, blk, off, wd);
    endtask

    task automatic rd(input logic [1:0] blk, input logic [7:0] off, input logic [7:0] exp,
                      input string tag);
        bus_we = 1'b0; bus_blk = blk; bus_off = off;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic lines_set(input int bitn, input logic v);
        logic [NL-1:0] l;
        l = m_prev;
        l[bitn] = v;
        step(l, 1'b0, 2'd0, 8'd0, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        for (int g = 0; g < NG; g++) begin
            m_req[g] = 4'h0; m_en[g] = 4'hF; m_lvl[g] = 3'd0;
        end
        m_trig = '0;
        m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(nmi_o === 1'b0 && irq_o === 1'b0 && irq_level_o === 3'd0, "R1 outputs",
            {nmi_o, irq_o, irq_level_o}, 0);
        rd(2'd0, 8'd17, 8'h0F, "R1 ctl1 group2");
        rd(2'd0, 8'd16, 8'h00, "R1 ctl0 group2");
        for (int b = 0; b < 7; b++) rd(2'd2, 8'(b), 8'h00, "R1 trig bytes");
        idle();

        // R3: falling-edge default; group5 line1 is bit 21
        lines_set(21, 1'b1);
        rd(2'd0, 8'd40, 8'h00, "R3 rise ignored in fall mode");
        lines_set(21, 1'b0);
        rd(2'd0, 8'd40, 8'h22, "R4 ctl0 IR/ID after fall");
        idle();
        chk(irq_o === 1'b1 && irq_level_o === 3'd0, "R9 irq up", {irq_o, irq_level_o}, 8);
        rd(2'd1, 8'd0, 8'd5, "R10 ack group5");
        rd(2'd0, 8'd240, 8'h22, "R2 alias offset 240");

        // R5: keep/set
        wr(2'd0, 8'd40, 8'h0D);
        rd(2'd0, 8'd40, 8'h00, "R5 keep clears bit1");
        wr(2'd0, 8'd40, 8'h44);
        rd(2'd0, 8'd40, 8'h44, "R5 set bit2");

        // R6: level/enable
        wr(2'd0, 8'd41, 8'h30);
        rd(2'd0, 8'd40, 8'h40, "R6 enables masked");
        rd(2'd0, 8'd41, 8'h30, "R6 ctl1 readback");
        idle();
        chk(irq_o === 1'b0, "R9 irq down", irq_o, 0);
        rd(2'd1, 8'd0, 8'd0, "R10 ack none");
        wr(2'd0, 8'd41, 8'h3F);

        // R9: priority; group9 line0 is bit 36
        lines_set(36, 1'b1);
        lines_set(36, 1'b0);
        rd(2'd1, 8'd0, 8'd9, "R9 lower level wins");
        idle();
        chk(irq_level_o === 3'd0, "R9 level0", irq_level_o, 0);
        wr(2'd0, 8'd73, 8'h3F);
        rd(2'd1, 8'd0, 8'd5, "R9 tie lower index wins");
        idle();
        chk(irq_level_o === 3'd3, "R9 level3", irq_level_o, 3);

        // R7/R8: non-maskable group0 line0
        lines_set(0, 1'b1);
        lines_set(0, 1'b0);
        rd(2'd0, 8'd0, 8'h01, "R7 nmi ctl0 read");
        idle();
        chk(nmi_o === 1'b1, "R8 nmi up", nmi_o, 1);
        wr(2'd0, 8'd1, 8'h70);
        rd(2'd0, 8'd1, 8'h00, "R7 nmi ctl1 reads zero");
        wr(2'd0, 8'd0, 8'h01);
        rd(2'd0, 8'd0, 8'h00, "R7 nmi cleared");
        idle();
        chk(nmi_o === 1'b0, "R8 nmi down", nmi_o, 0);

        // R12/R3: trigger modes; group2 line0 is bit 8
        wr(2'd2, 8'd0, 8'h10);
        rd(2'd2, 8'd0, 8'h10, "R12 trig byte0");
        lines_set(8, 1'b1);
        rd(2'd0, 8'd16, 8'h11, "R3 rising detect");
        wr(2'd2, 8'd6, 8'hFF);
        rd(2'd2, 8'd6, 8'h03, "R12 trig byte6 width");

        // R11: ignored writes and undefined offsets
        wr(2'd1, 8'd0, 8'hAA);
        rd(2'd1, 8'd0, 8'd2, "R11 ack write ignored");
        rd(2'd0, 8'd45, 8'h00, "R11 undefined ctl reg");
        rd(2'd3, 8'd0, 8'h00, "R11 block3");
        rd(2'd2, 8'd7, 8'h00, "R11 trig byte7");
        rd(2'd1, 8'd3, 8'h00, "R11 ack offset3");

        // Random phase against the model (R2..R12)
        for (int n = 0; n < 600; n++) begin
            logic [NL-1:0] l;
            logic we;
            logic [1:0] blk;
            logic [7:0] off;
            int g;
            l = m_prev;
            l[$urandom % NL] ^= 1'b1;
            l[$urandom % NL] ^= 1'b1;
            we = ($urandom % 4) == 0;
            blk = 2'($urandom % 4);
            off = (blk == 2'd0) ? {5'($urandom % 32), 3'($urandom % 3)} : 8'($urandom % 9);
            step(l, we, blk, off, 8'($urandom));
            g = $urandom % 32;
            rd(2'd0, 8'(g * 8), mrd(2'd0, 8'(g * 8)), "R4 random ctl0");
            rd(2'd0, 8'(g * 8 + 1), mrd(2'd0, 8'(g * 8 + 1)), "R6 random ctl1");
            rd(2'd1, 8'd0, mrd(2'd1, 8'd0), "R10 random ack");
            rd(2'd2, 8'(n % 8), mrd(2'd2, 8'(n % 8)), "R12 random trig");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule